// File: doc/BRIEF.md
# Mode-Selectable Mantissa Rounder

This block is a purely combinational rounding stage for a floating-point datapath. It receives an unsigned mantissa that carries two extra low-order bits, a guard bit above a round bit, plus a separate sticky bit and the sign of the value. It drops the two extra bits and adds one unit in the last place when the selected rounding direction requires it. It reports whether it rounded up, whether the result is inexact, and whether the increment carried out of the top bit.

A 2-bit mode input selects one of four rounding directions. The encoding is 00 nearest-even, 01 toward zero, 10 toward +inf and 11 toward -inf. The same mode and sign also decide the overflow target. This tells an upstream exponent stage whether an overflowing result becomes infinity or the largest finite magnitude. The rounder does not renormalise after a carry-out, handle the exponent, or trap exceptions.

Top module: `rnd_unit`

## Requirements
- R1: When guard (`mant_in[1]`), round (`mant_in[0]`) and `sticky_in` are all 0, `mant_out` equals `mant_in[MW+1:2]` and `inexact`, `inc_taken` and `carry_out` are all 0.
- R2: `inexact` is 1 whenever any one of guard, round or sticky is 1.
- R3: In mode 00, the block increments only when guard is 1 and at least one of round, sticky or `mant_in[2]` (the kept LSB) is 1, which gives ties to even.
- R4: In mode 01, `inc_taken` is always 0.
- R5: In mode 10, the block increments exactly when the result is inexact and `sign_in` is 0.
- R6: In mode 11, the block increments exactly when the result is inexact and `sign_in` is 1.
- R7: `{carry_out, mant_out}` equals `mant_in[MW+1:2] + inc_taken`, and `inc_taken` is 1 only if `inexact` is 1.
- R8: When the kept mantissa is all ones and an increment is applied, `carry_out` is 1 and `mant_out` is 0.
- R9: `ovf_to_inf` is 1 in mode 00, 0 in mode 01, equal to `!sign_in` in mode 10, and equal to `sign_in` in mode 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mant_in | input | MW+2 | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_in | input | 1 | OR of all bits below the round bit |
| sign_in | input | 1 | 1 = negative value |
| mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| mant_out | output | MW | Rounded mantissa without guard and round bits |
| carry_out | output | 1 | Carry out of the increment |
| inc_taken | output | 1 | An increment was applied |
| inexact | output | 1 | The discarded bits were not all zero |
| ovf_to_inf | output | 1 | On overflow, go to infinity (1) or largest finite (0) |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus, with no register in the path. The bench changes inputs just after a rising clock edge. It samples all outputs at the following falling edge, half a period later and with no edge in between. Each stimulus is therefore checked before the next one is applied.

// File: rtl/rnd_unit.sv
module rnd_unit #(
  parameter int MW = 24
) (
  input  logic [MW+1:0] mant_in,
  input  logic          sticky_in,
  input  logic          sign_in,
  input  logic [1:0]    mode,
  output logic [MW-1:0] mant_out,
  output logic          carry_out,
  output logic          inc_taken,
  output logic          inexact,
  output logic          ovf_to_inf
);

  localparam logic [1:0] M_NEAR = 2'b00;
  localparam logic [1:0] M_ZERO = 2'b01;
  localparam logic [1:0] M_PINF = 2'b10;
  localparam logic [1:0] M_NINF = 2'b11;

  logic [MW-1:0] kept;
  logic          grd, rnd;
  logic          up;

  assign kept    = mant_in[MW+1:2];
  assign grd     = mant_in[1];
  assign rnd     = mant_in[0];
  assign inexact = grd | rnd | sticky_in;

  always_comb begin
    unique case (mode)
      M_NEAR: up = grd & (rnd | sticky_in | kept[0]);
      M_ZERO: up = 1'b0;
      M_PINF: up = inexact & ~sign_in;
      M_NINF: up = inexact &  sign_in;
      default: up = 1'b0;
    endcase
  end

  always_comb begin
    unique case (mode)
      M_NEAR: ovf_to_inf = 1'b1;
      M_ZERO: ovf_to_inf = 1'b0;
      M_PINF: ovf_to_inf = ~sign_in;
      M_NINF: ovf_to_inf = sign_in;
      default: ovf_to_inf = 1'b0;
    endcase
  end

  assign inc_taken = up;
  assign {carry_out, mant_out} = {1'b0, kept} + {{MW{1'b0}}, up};

endmodule

module rnd_unit_chk #(
  parameter int MW = 24
) (
  input logic [MW+1:0] mant_in,
  input logic          sticky_in,
  input logic          sign_in,
  input logic [1:0]    mode,
  input logic [MW-1:0] mant_out,
  input logic          carry_out,
  input logic          inc_taken,
  input logic          inexact,
  input logic          ovf_to_inf
);

  always_comb begin
    if (mant_in[1:0] == 2'b00 && !sticky_in)
      assert_exact_R1: assert (!inexact && !inc_taken && !carry_out && mant_out == mant_in[MW+1:2]);
    if (mode == 2'b01)
      assert_no_inc_R4: assert (!inc_taken);
    assert_sum_R7: assert ({carry_out, mant_out} == {1'b0, mant_in[MW+1:2]} + {{MW{1'b0}}, inc_taken});
    if (inc_taken)
      assert_inc_inexact_R7: assert (inexact);
    if (mode == 2'b00)
      assert_ovf_near_R9: assert (ovf_to_inf);
    if (mode == 2'b01)
      assert_ovf_zero_R9: assert (!ovf_to_inf);
    if (mode == 2'b10 && inexact)
      assert_pinf_R5: assert (inc_taken == !sign_in);
    if (mode == 2'b11 && inexact)
      assert_ninf_R6: assert (inc_taken == sign_in);
  end

endmodule

bind rnd_unit rnd_unit_chk #(.MW(MW)) u_chk (
  .mant_in(mant_in), .sticky_in(sticky_in), .sign_in(sign_in), .mode(mode),
  .mant_out(mant_out), .carry_out(carry_out), .inc_taken(inc_taken),
  .inexact(inexact), .ovf_to_inf(ovf_to_inf)
);

// File: tb/sim_rnd_unit.sv
`timescale 1ns/1ps
module sim_rnd_unit;
  localparam int MW = 8;
  localparam int NV = 14;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [MW+1:0] mant_in = '0;
  logic sticky_in = 1'b0, sign_in = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [MW-1:0] mant_out;
  logic carry_out, inc_taken, inexact, ovf_to_inf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rnd_unit #(.MW(MW)) u0 (
    .mant_in(mant_in), .sticky_in(sticky_in), .sign_in(sign_in), .mode(mode),
    .mant_out(mant_out), .carry_out(carry_out), .inc_taken(inc_taken),
    .inexact(inexact), .ovf_to_inf(ovf_to_inf)
  );

  // {mode, sign, sticky, kept[8], guard/round[2], carry, out[8], inc, inexact, ovf}
  localparam logic [25:0] VEC [NV] = '{
    {2'd0,1'b0,1'b0,8'h55,2'b00, 1'b0,8'h55,1'b0,1'b0,1'b1},
    {2'd0,1'b0,1'b0,8'h54,2'b10, 1'b0,8'h54,1'b0,1'b1,1'b1},
    {2'd0,1'b0,1'b0,8'h55,2'b10, 1'b0,8'h56,1'b1,1'b1,1'b1},
    {2'd0,1'b0,1'b1,8'h54,2'b10, 1'b0,8'h55,1'b1,1'b1,1'b1},
    {2'd0,1'b0,1'b0,8'h54,2'b11, 1'b0,8'h55,1'b1,1'b1,1'b1},
    {2'd0,1'b0,1'b1,8'h54,2'b01, 1'b0,8'h54,1'b0,1'b1,1'b1},
    {2'd1,1'b1,1'b1,8'h7F,2'b11, 1'b0,8'h7F,1'b0,1'b1,1'b0},
    {2'd2,1'b0,1'b0,8'h10,2'b01, 1'b0,8'h11,1'b1,1'b1,1'b1},
    {2'd2,1'b1,1'b0,8'h10,2'b01, 1'b0,8'h10,1'b0,1'b1,1'b0},
    {2'd3,1'b1,1'b1,8'h10,2'b00, 1'b0,8'h11,1'b1,1'b1,1'b1},
    {2'd3,1'b0,1'b0,8'h10,2'b10, 1'b0,8'h10,1'b0,1'b1,1'b0},
    {2'd0,1'b0,1'b0,8'hFF,2'b11, 1'b1,8'h00,1'b1,1'b1,1'b1},
    {2'd2,1'b0,1'b0,8'h20,2'b00, 1'b0,8'h20,1'b0,1'b0,1'b1},
    {2'd3,1'b1,1'b0,8'hFF,2'b00, 1'b0,8'hFF,1'b0,1'b0,1'b1}
  };

  function automatic string vtag(int i);
    case (i)
      0, 12, 13: return "R1";
      1, 2, 3, 4, 5: return "R3";
      6: return "R4";
      7, 8: return "R5";
      9, 10: return "R6";
      11: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] m, logic s, logic st, logic [MW+1:0] mi);
    @(posedge clk);
    #1;
    mode = m; sign_in = s; sticky_in = st; mant_in = mi;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: idle all-zero inputs
    @(negedge clk);
    check("R1", {carry_out, mant_out, inc_taken, inexact, 1'b0}, 12'h000);
    check("R9", {11'd0, ovf_to_inf}, 12'h001);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][25:24], VEC[i][23], VEC[i][22], VEC[i][21:12]);
      check(vtag(i), {1'b0, carry_out, mant_out, inc_taken, inexact, ovf_to_inf}, {1'b0, VEC[i][11:0]});
    end

    // R2: each discarded bit alone raises inexact
    apply(2'd1, 1'b0, 1'b0, {8'h3C, 2'b10});
    check("R2", {11'd0, inexact}, 12'h001);
    apply(2'd1, 1'b0, 1'b0, {8'h3C, 2'b01});
    check("R2", {11'd0, inexact}, 12'h001);
    apply(2'd1, 1'b0, 1'b1, {8'h3C, 2'b00});
    check("R2", {11'd0, inexact}, 12'h001);

    // R4: toward zero leaves all-ones mantissa with every discarded bit set
    for (int s = 0; s < 2; s++) begin
      apply(2'd1, s[0], 1'b1, {8'hFF, 2'b11});
      check("R4", {2'b0, carry_out, mant_out, inc_taken}, {3'b000, 8'hFF, 1'b0});
    end

    // R9: overflow target matrix
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        logic e;
        apply(m[1:0], s[0], 1'b0, {8'h01, 2'b00});
        case (m)
          0: e = 1'b1;
          1: e = 1'b0;
          2: e = ~s[0];
          default: e = s[0];
        endcase
        check("R9", {11'd0, ovf_to_inf}, {11'd0, e});
      end
    end

    // R8 / R7: carry out in directed modes
    apply(2'd2, 1'b0, 1'b1, {8'hFF, 2'b00});
    check("R8", {3'b0, carry_out, mant_out}, {3'b0, 1'b1, 8'h00});
    apply(2'd3, 1'b1, 1'b0, {8'hFF, 2'b01});
    check("R8", {3'b0, carry_out, mant_out}, {3'b0, 1'b1, 8'h00});
    apply(2'd3, 1'b0, 1'b0, {8'hFF, 2'b01});
    check("R7", {2'b0, carry_out, mant_out, inc_taken}, {3'b0, 8'hFF, 1'b0});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule